// File: doc/BRIEF.md
# Thread Context Ring Matcher

This block decides whether an interrupt target, given as a block number and an index, is currently dispatched on one hardware thread. The thread keeps one context word and one valid bit for each of four privilege rings: physical, pool, OS and user. The matcher compares the target against those rings and reports which ring owns the target, or that none does. Context storage lives outside the block, and so does the delivery of the interrupt that follows a match.

A request is a single-cycle strobe that carries these fields:

- the target block and index;
- a format bit that picks either a specific-target lookup or a user-level branch lookup;
- an ignore bit that asks for a logical-server match;
- a logical-server number.

The physical ring holds no stored target word. Its compare line is built on the fly from the chip block ID, the thread ID and a marker bit. A mode input selects a 7-bit or an 8-bit thread ID for that line. The result is held in a register until the next request.

Top module: `ringMatchTop`

## Requirements
- R1: After reset, resValid, resRing and resUnsupported are all 0.
- R2: resValid is high in exactly the cycle after a cycle in which reqValid is sampled high. resRing and resUnsupported change only in those cycles and otherwise hold their last value.
- R3: The compare value is the 32-bit word {tgtBlock[7:0], tgtIndex[23:0]}. The pool and OS rings match only when the whole of poolCam or osCam equals this word.
- R4: With reqFormat=0 and reqIgnore=0, the rings are tried in a fixed order: physical first, then pool, then OS. The code of the first ring that matches is reported: 4 for physical, 3 for pool, 2 for OS. If none matches, the code is 0.
- R5: A ring never matches while its own valid bit (physValid, poolValid, osValid, userValid) is low, whatever its compare word holds.
- R6: The physical compare line is {chipBlock, low24}. When tid8Mode=0, low24 = 0x80 | threadId[6:0] and threadId[7] is ignored. When tid8Mode=1, low24 = 0x100 | threadId[7:0].
- R7: With reqFormat=1, the code is 1 only when all three hold: osValid=1 with osCam equal to the compare value, userValid=1, and reqServer equal to userServer. Otherwise the code is 0. The physical and pool rings are never reported in this format.
- R8: With reqFormat=0 and reqIgnore=1, the code is 0 and resUnsupported is 1. For every other request resUnsupported is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| tgtBlock | input | 8 | Target block number |
| tgtIndex | input | 24 | Target index |
| reqFormat | input | 1 | 0 specific target, 1 user-level branch |
| reqIgnore | input | 1 | Logical-server (ignore) request |
| reqServer | input | 12 | Logical-server number of the request |
| chipBlock | input | 8 | Block ID of this chip |
| threadId | input | 8 | Hardware thread ID |
| tid8Mode | input | 1 | 1 selects 8-bit thread IDs, 0 selects 7-bit |
| physValid | input | 1 | Physical ring valid |
| poolValid | input | 1 | Pool ring valid |
| poolCam | input | 32 | Pool ring target word |
| osValid | input | 1 | OS ring valid |
| osCam | input | 32 | OS ring target word |
| userValid | input | 1 | User ring valid |
| userServer | input | 12 | User ring logical-server number |
| resValid | output | 1 | Result strobe |
| resRing | output | 3 | Ring code: 0 none, 1 user, 2 OS, 3 pool, 4 physical |
| resUnsupported | output | 1 | Request was of the unsupported kind |

## Verification
The checker samples each result against context inputs one cycle old. It therefore assumes that the ring words, valid bits and target fields are stable in the cycle a request is sampled. The bench drives all inputs once per cycle, away from the active edge, which keeps that assumption true.

The bench also assumes the context words do not matter between requests. It changes them freely while reqValid is low, so that the hold behaviour is exercised. Random requests make the pool and OS words equal to the compare value often enough to reach every priority case.

// File: rtl/ringMatchPkg.sv
package ringMatchPkg;

  // Ring result codes. The numeric values are part of the output contract.
  typedef enum logic [2:0] {
    RING_NONE = 3'd0,
    RING_USER = 3'd1,
    RING_OS   = 3'd2,
    RING_POOL = 3'd3,
    RING_PHYS = 3'd4
  } ringCode_e;

  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic capture;   // load a new result this cycle
    logic specific;  // specific-target lookup (physical, pool, OS)
    logic user;      // user-level branch lookup
  } ctlStrobe_t;

endpackage

// File: rtl/ringMatchCtl.sv
module ringMatchCtl
  import ringMatchPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqFormat,
  input  logic       reqIgnore,
  output ctlStrobe_t strobe,
  output logic       resValid,
  output logic       resUnsupported
);

  logic unsuppReq;

  // Decode the request kind into strobes for the datapath.
  always_comb begin
    strobe.capture  = reqValid;
    strobe.specific = !reqFormat && !reqIgnore;
    strobe.user     = reqFormat;
    unsuppReq       = !reqFormat && reqIgnore;
  end

  // The result strobe pulses once; the unsupported flag holds until the next request.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid       <= 1'b0;
      resUnsupported <= 1'b0;
    end else begin
      resValid <= reqValid;
      if (reqValid) begin
        resUnsupported <= unsuppReq;
      end
    end
  end

endmodule

// File: rtl/ringMatchDp.sv
module ringMatchDp
  import ringMatchPkg::*;
#(
  parameter int BLK_W    = 8,
  parameter int IDX_W    = 24,
  parameter int TID_W    = 8,
  parameter int SERVER_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobe_t              strobe,
  input  logic [BLK_W-1:0]        tgtBlock,
  input  logic [IDX_W-1:0]        tgtIndex,
  input  logic [SERVER_W-1:0]     reqServer,
  input  logic [BLK_W-1:0]        chipBlock,
  input  logic [TID_W-1:0]        threadId,
  input  logic                    tid8Mode,
  input  logic                    physValid,
  input  logic                    poolValid,
  input  logic [BLK_W+IDX_W-1:0]  poolCam,
  input  logic                    osValid,
  input  logic [BLK_W+IDX_W-1:0]  osCam,
  input  logic                    userValid,
  input  logic [SERVER_W-1:0]     userServer,
  output logic [2:0]              resRing
);

  localparam int CAM_W  = BLK_W + IDX_W;
  localparam int N_RING = 3;  // compared rings: 0 physical, 1 pool, 2 OS
  localparam int R_PHYS = 0;
  localparam int R_POOL = 1;
  localparam int R_OS   = 2;

  logic [CAM_W-1:0] tgtCam;
  logic [IDX_W-1:0] physLow7;
  logic [IDX_W-1:0] physLow8;
  logic [IDX_W-1:0] physLow;
  logic [CAM_W-1:0] physCam;
  logic [CAM_W-1:0] ringCam [N_RING];
  logic             ringOn  [N_RING];
  logic [N_RING-1:0] hit;
  logic             userHit;
  ringCode_e        nextRing;

  assign tgtCam = {tgtBlock, tgtIndex};

  // Physical line: a marker bit just above the thread ID field, with the
  // field narrowed by one bit in the short thread-ID mode.
  assign physLow7 = IDX_W'(threadId[TID_W-2:0]) | (IDX_W'(1) << (TID_W - 1));
  assign physLow8 = IDX_W'(threadId)            | (IDX_W'(1) << TID_W);
  assign physLow  = tid8Mode ? physLow8 : physLow7;
  assign physCam  = {chipBlock, physLow};

  assign ringCam[R_PHYS] = physCam;
  assign ringCam[R_POOL] = poolCam;
  assign ringCam[R_OS]   = osCam;
  assign ringOn[R_PHYS]  = physValid;
  assign ringOn[R_POOL]  = poolValid;
  assign ringOn[R_OS]    = osValid;

  // One equality comparator per ring, gated by that ring's valid bit.
  for (genvar g = 0; g < N_RING; g++) begin : gRingCmp
    assign hit[g] = ringOn[g] && (ringCam[g] == tgtCam);
  end

  // The user ring also needs the OS ring to match.
  assign userHit = hit[R_OS] && userValid && (reqServer == userServer);

  always_comb begin
    nextRing = RING_NONE;
    if (strobe.specific) begin
      if (hit[R_PHYS]) begin
        nextRing = RING_PHYS;
      end else if (hit[R_POOL]) begin
        nextRing = RING_POOL;
      end else if (hit[R_OS]) begin
        nextRing = RING_OS;
      end
    end else if (strobe.user) begin
      if (userHit) begin
        nextRing = RING_USER;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resRing <= RING_NONE;
    end else if (strobe.capture) begin
      resRing <= nextRing;
    end
  end

endmodule

// File: rtl/ringMatchTop.sv
module ringMatchTop
  import ringMatchPkg::*;
#(
  parameter int BLK_W    = 8,
  parameter int IDX_W    = 24,
  parameter int TID_W    = 8,
  parameter int SERVER_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [BLK_W-1:0]        tgtBlock,
  input  logic [IDX_W-1:0]        tgtIndex,
  input  logic                    reqFormat,
  input  logic                    reqIgnore,
  input  logic [SERVER_W-1:0]     reqServer,
  input  logic [BLK_W-1:0]        chipBlock,
  input  logic [TID_W-1:0]        threadId,
  input  logic                    tid8Mode,
  input  logic                    physValid,
  input  logic                    poolValid,
  input  logic [BLK_W+IDX_W-1:0]  poolCam,
  input  logic                    osValid,
  input  logic [BLK_W+IDX_W-1:0]  osCam,
  input  logic                    userValid,
  input  logic [SERVER_W-1:0]     userServer,
  output logic                    resValid,
  output logic [2:0]              resRing,
  output logic                    resUnsupported
);

  ctlStrobe_t strobe;

  ringMatchCtl u_ctl (
    .clk            (clk),
    .rstN           (rstN),
    .reqValid       (reqValid),
    .reqFormat      (reqFormat),
    .reqIgnore      (reqIgnore),
    .strobe         (strobe),
    .resValid       (resValid),
    .resUnsupported (resUnsupported)
  );

  ringMatchDp #(
    .BLK_W    (BLK_W),
    .IDX_W    (IDX_W),
    .TID_W    (TID_W),
    .SERVER_W (SERVER_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .tgtBlock   (tgtBlock),
    .tgtIndex   (tgtIndex),
    .reqServer  (reqServer),
    .chipBlock  (chipBlock),
    .threadId   (threadId),
    .tid8Mode   (tid8Mode),
    .physValid  (physValid),
    .poolValid  (poolValid),
    .poolCam    (poolCam),
    .osValid    (osValid),
    .osCam      (osCam),
    .userValid  (userValid),
    .userServer (userServer),
    .resRing    (resRing)
  );

endmodule

// File: rtl/ringMatchChecker.sv
module ringMatchChecker #(
  parameter int BLK_W = 8,
  parameter int IDX_W = 24
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic [BLK_W-1:0]       tgtBlock,
  input logic [IDX_W-1:0]       tgtIndex,
  input logic                   reqFormat,
  input logic                   reqIgnore,
  input logic                   physValid,
  input logic                   poolValid,
  input logic                   osValid,
  input logic [BLK_W+IDX_W-1:0] osCam,
  input logic                   userValid,
  input logic                   resValid,
  input logic [2:0]             resRing,
  input logic                   resUnsupported
);

  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);

  assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resValid);

  assert_ring_code_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    resRing <= 3'd4);

  assert_phys_needs_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resRing == 3'd4) |-> $past(physValid && !reqFormat));

  assert_pool_needs_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resRing == 3'd3) |-> $past(poolValid && !reqFormat));

  assert_os_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resRing == 3'd2) |-> $past(osValid && osCam == {tgtBlock, tgtIndex}));

  assert_user_needs_os_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resRing == 3'd1) |->
      $past(reqFormat && userValid && osValid && osCam == {tgtBlock, tgtIndex}));

  assert_user_format_codes_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && $past(reqFormat)) |-> (resRing <= 3'd1));

  assert_unsupported_no_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resUnsupported) |-> (resRing == 3'd0 && $past(!reqFormat && reqIgnore)));

  assert_unsupported_only_when_asked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && $past(!(!reqFormat && reqIgnore))) |-> !resUnsupported);

endmodule

bind ringMatchTop ringMatchChecker #(
  .BLK_W (BLK_W),
  .IDX_W (IDX_W)
) u_check (
  .clk            (clk),
  .rstN           (rstN),
  .reqValid       (reqValid),
  .tgtBlock       (tgtBlock),
  .tgtIndex       (tgtIndex),
  .reqFormat      (reqFormat),
  .reqIgnore      (reqIgnore),
  .physValid      (physValid),
  .poolValid      (poolValid),
  .osValid        (osValid),
  .osCam          (osCam),
  .userValid      (userValid),
  .resValid       (resValid),
  .resRing        (resRing),
  .resUnsupported (resUnsupported)
);

// File: tb/ringMatchTop_bench.sv
`timescale 1ns/1ps
module ringMatchTop_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [7:0]  tgtBlock;
  logic [23:0] tgtIndex;
  logic        reqFormat;
  logic        reqIgnore;
  logic [11:0] reqServer;
  logic [7:0]  chipBlock;
  logic [7:0]  threadId;
  logic        tid8Mode;
  logic        physValid;
  logic        poolValid;
  logic [31:0] poolCam;
  logic        osValid;
  logic [31:0] osCam;
  logic        userValid;
  logic [11:0] userServer;
  logic        resValid;
  logic [2:0]  resRing;
  logic        resUnsupported;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference state: what the outputs must show after the next edge.
  logic expValid = 0;
  int   expRing  = 0;
  logic expUns   = 0;

  always #2.5 clk = ~clk;

  ringMatchTop u_ringMatchTop (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .tgtBlock(tgtBlock),
    .tgtIndex(tgtIndex), .reqFormat(reqFormat), .reqIgnore(reqIgnore),
    .reqServer(reqServer), .chipBlock(chipBlock), .threadId(threadId),
    .tid8Mode(tid8Mode), .physValid(physValid), .poolValid(poolValid),
    .poolCam(poolCam), .osValid(osValid), .osCam(osCam),
    .userValid(userValid), .userServer(userServer), .resValid(resValid),
    .resRing(resRing), .resUnsupported(resUnsupported)
  );

  function automatic logic [31:0] physLine();
    logic [31:0] low;
    if (tid8Mode) low = 32'h100 + {24'h0, threadId};
    else          low = 32'h80 + {25'h0, threadId[6:0]};
    return ({chipBlock, 24'h0}) | low;
  endfunction

  function automatic int refRing();
    logic [31:0] target = {tgtBlock, tgtIndex};
    if (reqFormat) begin
      if (osValid && osCam == target && userValid && reqServer == userServer) return 1;
      return 0;
    end
    if (reqIgnore) return 0;
    if (physValid && physLine() == target) return 4;
    if (poolValid && poolCam == target) return 3;
    if (osValid && osCam == target) return 2;
    return 0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Advance one cycle with the inputs now driven, then compare all outputs.
  task automatic step(string tag);
    if (reqValid) begin
      expRing = refRing();
      expUns  = !reqFormat && reqIgnore;
    end
    expValid = reqValid;
    @(negedge clk);
    check(tag, "resValid", int'(resValid), int'(expValid));
    check(tag, "resRing", int'(resRing), expRing);
    check(tag, "resUnsupported", int'(resUnsupported), int'(expUns));
  endtask

  task automatic clearCtx();
    reqValid = 0; reqFormat = 0; reqIgnore = 0; reqServer = 0;
    physValid = 0; poolValid = 0; osValid = 0; userValid = 0;
    poolCam = 0; osCam = 0; userServer = 0;
  endtask

  initial begin
    rstN = 0;
    tgtBlock = 0; tgtIndex = 0; chipBlock = 8'h5a; threadId = 8'h93; tid8Mode = 0;
    clearCtx();
    repeat (3) @(negedge clk);
    check("R1", "resValid", int'(resValid), 0);
    check("R1", "resRing", int'(resRing), 0);
    check("R1", "resUnsupported", int'(resUnsupported), 0);
    rstN = 1;
    step("R1");

    // R6: 7-bit mode, thread bit 7 dropped: line 0x5a000093 & ~0x80 | 0x80 = 0x5a000093
    physValid = 1; reqValid = 1; tgtBlock = 8'h5a; tgtIndex = 24'h000093; step("R6");
    tgtIndex = 24'h000193; step("R6");                 // 8-bit form must not match
    tid8Mode = 1; step("R6");                          // 8-bit mode line 0x5a000193
    tgtIndex = 24'h000093; step("R6");
    threadId = 8'h13; tid8Mode = 0; step("R6");        // 7-bit line 0x5a000093 again
    // R5: valid bit low blocks the physical ring
    physValid = 0; step("R5");
    // R4: priority with all three rings matching
    physValid = 1; poolValid = 1; osValid = 1; poolCam = 32'h5a000093; osCam = 32'h5a000093;
    step("R4");
    physValid = 0; step("R4");
    poolValid = 0; step("R4");
    osValid = 0; step("R4");
    poolValid = 1; poolCam = 32'h5b000093; step("R3");  // block differs
    tgtBlock = 8'h5b; step("R3");
    // R2: idle cycles hold result while context changes
    reqValid = 0; poolValid = 0; step("R2"); step("R2");
    // R7: user format
    reqValid = 1; reqFormat = 1; tgtBlock = 8'h12; tgtIndex = 24'h345678;
    osValid = 1; osCam = 32'h12345678; userValid = 1; reqServer = 12'h3c1; userServer = 12'h3c1;
    physValid = 1; chipBlock = 8'h12; threadId = 8'h78; tid8Mode = 1;
    step("R7");
    userServer = 12'h3c2; step("R7");
    userServer = 12'h3c1; userValid = 0; step("R7");
    userValid = 1; osValid = 0; step("R7");
    osValid = 1; osCam = 32'h12345679; step("R7");
    // phys matches but format 1 reports nothing: line 0x12000178
    tgtIndex = 24'h000178; step("R7");
    // R8: unsupported logical-server request, then cleared by a normal one
    reqFormat = 0; reqIgnore = 1; osCam = 32'h12000178; step("R8");
    reqValid = 0; reqIgnore = 0; step("R8");
    reqValid = 1; step("R8");
    reqIgnore = 1; reqFormat = 1; step("R8");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      reqValid  = r[0] | r[1];
      reqFormat = r[2] & r[3];
      reqIgnore = r[4] & r[5];
      tid8Mode  = r[6];
      physValid = r[7]; poolValid = r[8]; osValid = r[9]; userValid = r[10];
      tgtBlock  = r[11] ? chipBlock : 8'($urandom);
      threadId  = 8'($urandom);
      if (r[12]) tgtIndex = tid8Mode ? (24'h100 | threadId) : (24'h80 | threadId[6:0]);
      else       tgtIndex = 24'($urandom % 4);
      poolCam    = r[13] ? {tgtBlock, tgtIndex} : $urandom;
      osCam      = r[14] ? {tgtBlock, tgtIndex} : $urandom;
      reqServer  = 12'($urandom % 3);
      userServer = 12'($urandom % 3);
      step(reqFormat ? "R7" : (reqIgnore ? "R8" : "R4"));
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule